// File: doc/BRIEF.md
# Per-Port Frame Statistics Counters

This block keeps traffic statistics for every port of a multi-port Ethernet switch. For each port the MAC signals the end of each received and each transmitted frame with a one-cycle strobe. The strobe comes with the frame length, a set of qualifier flags and, on transmit, the number of collisions the frame met. The block classifies each frame. It bumps event counters, sorts good-length frames into size buckets and adds byte totals. Each port has its own bank of counters.

Software reads the counters through a simple read port that takes a byte address. A read returns the selected counter one cycle later and clears that counter in the same step. A poller therefore sees only the events since its previous read. An event that arrives in the cycle of the read is kept: it becomes the first count after the clear. Counters wrap at their width and never saturate, so the poll interval must be short enough to avoid losing a wrap.

Top module: `mib_counters`

## Requirements
- R1: After reset every counter of every port reads as zero, and rd_valid and rd_data are zero.
- R2: A read address hits when rd_addr[ADDR_W-1:16] equals REGION (default 2, so banks start at 0x20000), rd_addr[1:0] is 0, rd_addr[15:8] is a port below NUM_PORTS and rd_addr[7:2] is a word below 37. Data appears on rd_data with rd_valid high in the cycle after rd_en. rd_data is zero in any cycle not following a read.
- R3: A read clears the counter it returns, so a second read with no new events returns zero.
- R4: If a counter is incremented in the same cycle it is read, the read returns the old value and the counter restarts at the increment amount.
- R5: A read of an unused word (37 to 63), of a port at or above NUM_PORTS, of a misaligned address or of another region returns zero and clears nothing.
- R6: Receive words 0/1/2/8/9 count frames carrying rx_flags bits 0 (broadcast), 1 (multicast), 2 (pause), 5 (overflow) and 6 (filtered) respectively.
- R7: Receive words 3 and 4 count rx_flags bits 3 (FCS error) and 4 (alignment error). A frame shorter than 64 bytes counts in word 5 (runt) when neither error flag is set, and otherwise in word 6 (fragment). A frame longer than MAX_FRAME counts in word 7.
- R8: Receive frames of 64 to MAX_FRAME bytes count in exactly one bucket: word 10 for 64, word 11 for 65–127, word 12 for 128–255, word 13 for 256–511, word 14 for 512–1023, word 15 for 1024–1518 and word 16 for 1519–MAX_FRAME.
- R9: A receive frame with a length of 64 to MAX_FRAME and none of flags 3, 4 and 5 adds its length to word 17 (good bytes). Any other frame adds its length to word 18 (bad bytes).
- R10: Transmit words 19/20/21/22/35/36 count tx_flags bits 0 (broadcast), 1 (multicast), 2 (pause), 3 (underrun), 4 (late collision) and 5 (deferred). A frame longer than MAX_FRAME counts in word 23 (oversize). Otherwise it goes into word 24 for up to 64 bytes, then words 25–30 using the same ranges as R8.
- R11: Word 31 adds every transmitted length. Word 32 adds tx_coll. Word 33 counts frames with exactly one collision, and word 34 counts frames with more than one.
- R12: Counters wrap modulo 2^CNT_W.
- R13: The events of one port change only that port's bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | NUM_PORTS | End-of-received-frame strobe per port |
| rx_len | input | NUM_PORTS x LEN_W | Received frame length in bytes |
| rx_flags | input | NUM_PORTS x 7 | Receive qualifiers (see R6, R7) |
| tx_done | input | NUM_PORTS | End-of-transmitted-frame strobe per port |
| tx_len | input | NUM_PORTS x LEN_W | Transmitted frame length in bytes |
| tx_flags | input | NUM_PORTS x 6 | Transmit qualifiers (see R10) |
| tx_coll | input | NUM_PORTS x COLL_W | Collisions seen by the transmitted frame |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Byte address of the counter |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | CNT_W | Counter value returned by the read |

## Verification
The bench builds the block with six ports, MAX_FRAME of 1536 and CNT_W set to 16 in place of 32. The narrow width makes a wrap reachable in a few dozen 1500-byte frames, and the bench checks the byte total modulo 2^16 after that run. The 1536-byte limit leaves room to probe both edges of the top bucket, 1519 and 1536, and the first oversized length, 1537. Every port takes part, so bank separation and the out-of-range port decode are both exercised.

// File: rtl/mib_pkg.sv
package mib_pkg;
    // Counter word indices inside one bank (byte offset = index * 4)
    localparam int RX_BCAST  = 0;
    localparam int RX_MCAST  = 1;
    localparam int RX_PAUSE  = 2;
    localparam int RX_FCS    = 3;
    localparam int RX_ALIGN  = 4;
    localparam int RX_RUNT   = 5;
    localparam int RX_FRAG   = 6;
    localparam int RX_LONG   = 7;
    localparam int RX_OVF    = 8;
    localparam int RX_FILT   = 9;
    localparam int RX_BIN0   = 10;
    localparam int RX_GOODB  = 17;
    localparam int RX_BADB   = 18;
    localparam int TX_BCAST  = 19;
    localparam int TX_MCAST  = 20;
    localparam int TX_PAUSE  = 21;
    localparam int TX_UNDER  = 22;
    localparam int TX_OVSZ   = 23;
    localparam int TX_BIN0   = 24;
    localparam int TX_BYTES  = 31;
    localparam int TX_COLL   = 32;
    localparam int TX_SCOL   = 33;
    localparam int TX_MCOL   = 34;
    localparam int TX_LATE   = 35;
    localparam int TX_DEFER  = 36;
    localparam int NUM_CNT   = 37;
    localparam int NUM_BINS  = 7;
    localparam int WORD_W    = 6;

    // Receive flag bit positions
    localparam int RXF_BCAST = 0;
    localparam int RXF_MCAST = 1;
    localparam int RXF_PAUSE = 2;
    localparam int RXF_FCS   = 3;
    localparam int RXF_ALIGN = 4;
    localparam int RXF_OVF   = 5;
    localparam int RXF_FILT  = 6;
    localparam int RXF_W     = 7;

    // Transmit flag bit positions
    localparam int TXF_BCAST = 0;
    localparam int TXF_MCAST = 1;
    localparam int TXF_PAUSE = 2;
    localparam int TXF_UNDER = 3;
    localparam int TXF_LATE  = 4;
    localparam int TXF_DEFER = 5;
    localparam int TXF_W     = 6;

    localparam int MIN_LEN   = 64;
    localparam int STD_LEN   = 1518;

    // Size bucket of a frame that already lies inside the binned range
    function automatic logic [2:0] bin_of(input logic [31:0] len);
        if (len <= 32'(MIN_LEN))      return 3'd0;
        else if (len < 32'd128)       return 3'd1;
        else if (len < 32'd256)       return 3'd2;
        else if (len < 32'd512)       return 3'd3;
        else if (len < 32'd1024)      return 3'd4;
        else if (len <= 32'(STD_LEN)) return 3'd5;
        else                          return 3'd6;
    endfunction
endpackage

// File: rtl/mib_classify.sv
module mib_classify import mib_pkg::*; #(
    parameter int LEN_W     = 14,
    parameter int COLL_W    = 4,
    parameter int MAX_FRAME = 1536
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rx_done,
    input  logic [LEN_W-1:0]                 rx_len,
    input  logic [RXF_W-1:0]                 rx_flags,
    input  logic                             tx_done,
    input  logic [LEN_W-1:0]                 tx_len,
    input  logic [TXF_W-1:0]                 tx_flags,
    input  logic [COLL_W-1:0]                tx_coll,
    output logic [NUM_CNT-1:0][LEN_W-1:0]    inc
);
    logic [31:0] rx_l, tx_l;
    logic        rx_err, rx_inrange;

    assign rx_l       = 32'(rx_len);
    assign tx_l       = 32'(tx_len);
    assign rx_err     = rx_flags[RXF_FCS] | rx_flags[RXF_ALIGN];
    assign rx_inrange = (rx_l >= 32'(MIN_LEN)) && (rx_l <= 32'(MAX_FRAME));

    always_comb begin
        inc = '0;
        if (rx_done) begin
            inc[RX_BCAST] = LEN_W'(rx_flags[RXF_BCAST]);
            inc[RX_MCAST] = LEN_W'(rx_flags[RXF_MCAST]);
            inc[RX_PAUSE] = LEN_W'(rx_flags[RXF_PAUSE]);
            inc[RX_FCS]   = LEN_W'(rx_flags[RXF_FCS]);
            inc[RX_ALIGN] = LEN_W'(rx_flags[RXF_ALIGN]);
            inc[RX_OVF]   = LEN_W'(rx_flags[RXF_OVF]);
            inc[RX_FILT]  = LEN_W'(rx_flags[RXF_FILT]);
            if (rx_l < 32'(MIN_LEN)) begin
                if (rx_err) inc[RX_FRAG] = LEN_W'(1);
                else        inc[RX_RUNT] = LEN_W'(1);
            end else if (rx_l > 32'(MAX_FRAME)) begin
                inc[RX_LONG] = LEN_W'(1);
            end else begin
                inc[RX_BIN0 + int'(bin_of(rx_l))] = LEN_W'(1);
            end
            if (rx_inrange && !rx_err && !rx_flags[RXF_OVF]) inc[RX_GOODB] = rx_len;
            else                                             inc[RX_BADB]  = rx_len;
        end
        if (tx_done) begin
            inc[TX_BCAST] = LEN_W'(tx_flags[TXF_BCAST]);
            inc[TX_MCAST] = LEN_W'(tx_flags[TXF_MCAST]);
            inc[TX_PAUSE] = LEN_W'(tx_flags[TXF_PAUSE]);
            inc[TX_UNDER] = LEN_W'(tx_flags[TXF_UNDER]);
            inc[TX_LATE]  = LEN_W'(tx_flags[TXF_LATE]);
            inc[TX_DEFER] = LEN_W'(tx_flags[TXF_DEFER]);
            if (tx_l > 32'(MAX_FRAME)) inc[TX_OVSZ] = LEN_W'(1);
            else                       inc[TX_BIN0 + int'(bin_of(tx_l))] = LEN_W'(1);
            inc[TX_BYTES] = tx_len;
            inc[TX_COLL]  = LEN_W'(tx_coll);
            inc[TX_SCOL]  = LEN_W'(tx_coll == COLL_W'(1));
            inc[TX_MCOL]  = LEN_W'(tx_coll > COLL_W'(1));
        end
    end

    // Bucket hit vectors, used only by the checks below
    logic [NUM_BINS-1:0] rx_bin_hit, tx_bin_hit;
    always_comb begin
        for (int b = 0; b < NUM_BINS; b++) begin
            rx_bin_hit[b] = inc[RX_BIN0 + b] != '0;
            tx_bin_hit[b] = inc[TX_BIN0 + b] != '0;
        end
    end

    // R8: a received frame lands in at most one bucket
    p_rx_one_bin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_bin_hit));
    // R7: each received frame has exactly one length class
    p_rx_len_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> $countones({inc[RX_RUNT] != '0, inc[RX_FRAG] != '0,
                                inc[RX_LONG] != '0, |rx_bin_hit}) == 1);
    // R9: a non-empty received frame feeds exactly one byte total
    p_rx_byte_split_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_len != '0) |-> $countones({inc[RX_GOODB] != '0, inc[RX_BADB] != '0}) == 1);
    // R10: a transmitted frame is either binned or oversize, never both
    p_tx_class_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> $countones({inc[TX_OVSZ] != '0, |tx_bin_hit}) == 1);
endmodule

// File: rtl/mib_bank.sv
module mib_bank import mib_pkg::*; #(
    parameter int CNT_W = 32,
    parameter int LEN_W = 14
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CNT-1:0][LEN_W-1:0] inc,
    input  logic [NUM_CNT-1:0]            clr,
    output logic [NUM_CNT-1:0][CNT_W-1:0] cnt
);
    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CNT; i++) begin
            // A read restarts the word from the increment of this same cycle
            st_d.cnt[i] = (clr[i] ? '0 : st_q.cnt[i]) + CNT_W'(inc[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    // R3: one read clears at most one word of a bank
    p_clr_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        // R4: after a read the word holds only the increment of the read cycle
        p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
            clr[i] |=> st_q.cnt[i] == CNT_W'($past(inc[i])));
    end
endmodule

// File: rtl/mib_counters.sv
module mib_counters import mib_pkg::*; #(
    parameter int NUM_PORTS = 6,
    parameter int CNT_W     = 32,
    parameter int LEN_W     = 14,
    parameter int COLL_W    = 4,
    parameter int MAX_FRAME = 1536,
    parameter int ADDR_W    = 18,
    parameter int REGION    = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_PORTS-1:0]                  rx_done,
    input  logic [NUM_PORTS-1:0][LEN_W-1:0]       rx_len,
    input  logic [NUM_PORTS-1:0][RXF_W-1:0]       rx_flags,
    input  logic [NUM_PORTS-1:0]                  tx_done,
    input  logic [NUM_PORTS-1:0][LEN_W-1:0]       tx_len,
    input  logic [NUM_PORTS-1:0][TXF_W-1:0]       tx_flags,
    input  logic [NUM_PORTS-1:0][COLL_W-1:0]      tx_coll,
    input  logic                                  rd_en,
    input  logic [ADDR_W-1:0]                     rd_addr,
    output logic                                  rd_valid,
    output logic [CNT_W-1:0]                      rd_data
);
    localparam int HI_W   = ADDR_W - 16;
    localparam int PORT_W = 8;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] data;
    } rd_t;

    logic [NUM_PORTS-1:0][NUM_CNT-1:0][LEN_W-1:0] inc_all;
    logic [NUM_PORTS-1:0][NUM_CNT-1:0][CNT_W-1:0] cnt_all;
    logic [NUM_PORTS-1:0][NUM_CNT-1:0]            clr_all;
    logic                                         region_ok;
    logic [PORT_W-1:0]                            sel_port;
    logic [WORD_W-1:0]                            sel_word;
    rd_t                                          rd_d, rd_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mib_classify #(
            .LEN_W(LEN_W), .COLL_W(COLL_W), .MAX_FRAME(MAX_FRAME)
        ) u_classify (
            .clk(clk), .rst_n(rst_n),
            .rx_done(rx_done[p]), .rx_len(rx_len[p]), .rx_flags(rx_flags[p]),
            .tx_done(tx_done[p]), .tx_len(tx_len[p]), .tx_flags(tx_flags[p]),
            .tx_coll(tx_coll[p]), .inc(inc_all[p])
        );
        mib_bank #(
            .CNT_W(CNT_W), .LEN_W(LEN_W)
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .inc(inc_all[p]), .clr(clr_all[p]), .cnt(cnt_all[p])
        );
    end

    assign region_ok = (rd_addr[ADDR_W-1:16] == HI_W'(REGION)) && (rd_addr[1:0] == 2'b00);
    assign sel_port  = rd_addr[15:8];
    assign sel_word  = rd_addr[7:2];

    always_comb begin
        clr_all    = '0;
        rd_d.valid = rd_en;
        rd_d.data  = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            for (int w = 0; w < NUM_CNT; w++) begin
                if (rd_en && region_ok && sel_port == PORT_W'(p) && sel_word == WORD_W'(w)) begin
                    clr_all[p][w] = 1'b1;
                    rd_d.data     = cnt_all[p][w];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    // R2: data is valid exactly one cycle after a request
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && rd_data == '0));
    // R5: unused words inside a bank read as zero
    p_unused_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr[7:2] >= WORD_W'(NUM_CNT)) |=> rd_data == '0);
    // R5: an address outside the banks touches no counter
    p_miss_no_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !region_ok |-> clr_all == '0);
endmodule

// File: tb/mib_counters_bench.sv
`timescale 1ns/1ps
module mib_counters_bench;
    localparam int NP = 6;
    localparam int CW = 16;
    localparam int LW = 14;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NP-1:0]         rx_done = '0;
    logic [NP-1:0][LW-1:0] rx_len = '0;
    logic [NP-1:0][6:0]    rx_flags = '0;
    logic [NP-1:0]         tx_done = '0;
    logic [NP-1:0][LW-1:0] tx_len = '0;
    logic [NP-1:0][5:0]    tx_flags = '0;
    logic [NP-1:0][3:0]    tx_coll = '0;
    logic                  rd_en = 1'b0;
    logic [17:0]           rd_addr = '0;
    logic                  rd_valid;
    logic [CW-1:0]         rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    mib_counters #(
        .NUM_PORTS(NP), .CNT_W(CW), .LEN_W(LW), .COLL_W(4),
        .MAX_FRAME(1536), .ADDR_W(18), .REGION(2)
    ) u_mib_counters (
        .clk(clk), .rst_n(rst_n),
        .rx_done(rx_done), .rx_len(rx_len), .rx_flags(rx_flags),
        .tx_done(tx_done), .tx_len(tx_len), .tx_flags(tx_flags), .tx_coll(tx_coll),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    typedef struct packed {
        logic        tx;
        logic [2:0]  port;
        logic [13:0] len;
        logic [6:0]  flags;
        logic [3:0]  coll;
        logic [5:0]  word;
        logic [15:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 3'd0, 14'd64,   7'h01, 4'd0, 6'd0,  16'd1,   4'd6},  // R6 bcast
        '{1'b0, 3'd1, 14'd100,  7'h02, 4'd0, 6'd1,  16'd1,   4'd6},  // R6 mcast
        '{1'b0, 3'd2, 14'd64,   7'h04, 4'd0, 6'd2,  16'd1,   4'd6},  // R6 pause
        '{1'b0, 3'd3, 14'd200,  7'h08, 4'd0, 6'd3,  16'd1,   4'd7},  // R7 fcs
        '{1'b0, 3'd4, 14'd300,  7'h10, 4'd0, 6'd4,  16'd1,   4'd7},  // R7 align
        '{1'b0, 3'd5, 14'd40,   7'h00, 4'd0, 6'd5,  16'd1,   4'd7},  // R7 runt
        '{1'b0, 3'd0, 14'd40,   7'h08, 4'd0, 6'd6,  16'd1,   4'd7},  // R7 fragment
        '{1'b0, 3'd1, 14'd1600, 7'h00, 4'd0, 6'd7,  16'd1,   4'd7},  // R7 too long
        '{1'b0, 3'd2, 14'd70,   7'h20, 4'd0, 6'd8,  16'd1,   4'd6},  // R6 overflow
        '{1'b0, 3'd3, 14'd80,   7'h40, 4'd0, 6'd9,  16'd1,   4'd6},  // R6 filtered
        '{1'b0, 3'd0, 14'd64,   7'h00, 4'd0, 6'd10, 16'd1,   4'd8},  // R8 bin 64
        '{1'b0, 3'd0, 14'd127,  7'h00, 4'd0, 6'd11, 16'd1,   4'd8},  // R8
        '{1'b0, 3'd0, 14'd128,  7'h00, 4'd0, 6'd12, 16'd1,   4'd8},  // R8
        '{1'b0, 3'd0, 14'd256,  7'h00, 4'd0, 6'd13, 16'd1,   4'd8},  // R8
        '{1'b0, 3'd0, 14'd1023, 7'h00, 4'd0, 6'd14, 16'd1,   4'd8},  // R8
        '{1'b0, 3'd0, 14'd1518, 7'h00, 4'd0, 6'd15, 16'd1,   4'd8},  // R8
        '{1'b0, 3'd0, 14'd1519, 7'h00, 4'd0, 6'd16, 16'd1,   4'd8},  // R8
        '{1'b0, 3'd0, 14'd1536, 7'h00, 4'd0, 6'd16, 16'd1,   4'd8},  // R8 max edge
        '{1'b0, 3'd0, 14'd1537, 7'h00, 4'd0, 6'd16, 16'd0,   4'd8},  // R8 beyond max
        '{1'b0, 3'd0, 14'd65,   7'h00, 4'd0, 6'd10, 16'd0,   4'd8},  // R8 65 not in first
        '{1'b0, 3'd1, 14'd500,  7'h00, 4'd0, 6'd17, 16'd500, 4'd9},  // R9 good bytes
        '{1'b0, 3'd1, 14'd500,  7'h08, 4'd0, 6'd18, 16'd500, 4'd9},  // R9 bad bytes
        '{1'b0, 3'd1, 14'd500,  7'h08, 4'd0, 6'd17, 16'd0,   4'd9},  // R9
        '{1'b0, 3'd1, 14'd500,  7'h20, 4'd0, 6'd17, 16'd0,   4'd9},  // R9 overflow is bad
        '{1'b1, 3'd2, 14'd64,   7'h01, 4'd0, 6'd19, 16'd1,   4'd10}, // R10
        '{1'b1, 3'd2, 14'd64,   7'h02, 4'd0, 6'd20, 16'd1,   4'd10}, // R10
        '{1'b1, 3'd2, 14'd64,   7'h04, 4'd0, 6'd21, 16'd1,   4'd10}, // R10
        '{1'b1, 3'd2, 14'd64,   7'h08, 4'd0, 6'd22, 16'd1,   4'd10}, // R10
        '{1'b1, 3'd2, 14'd1600, 7'h00, 4'd0, 6'd23, 16'd1,   4'd10}, // R10 oversize
        '{1'b1, 3'd2, 14'd60,   7'h00, 4'd0, 6'd24, 16'd1,   4'd10}, // R10 short in first
        '{1'b1, 3'd2, 14'd600,  7'h00, 4'd0, 6'd28, 16'd1,   4'd10}, // R10
        '{1'b1, 3'd2, 14'd1536, 7'h00, 4'd0, 6'd30, 16'd1,   4'd10}, // R10
        '{1'b1, 3'd2, 14'd1600, 7'h00, 4'd0, 6'd30, 16'd0,   4'd10}, // R10
        '{1'b1, 3'd3, 14'd900,  7'h00, 4'd0, 6'd31, 16'd900, 4'd11}, // R11 bytes
        '{1'b1, 3'd3, 14'd100,  7'h00, 4'd3, 6'd32, 16'd3,   4'd11}, // R11 coll sum
        '{1'b1, 3'd3, 14'd100,  7'h00, 4'd3, 6'd34, 16'd1,   4'd11}, // R11 multi
        '{1'b1, 3'd3, 14'd100,  7'h00, 4'd3, 6'd33, 16'd0,   4'd11}, // R11
        '{1'b1, 3'd3, 14'd100,  7'h00, 4'd1, 6'd33, 16'd1,   4'd11}, // R11 single
        '{1'b1, 3'd4, 14'd100,  7'h10, 4'd0, 6'd35, 16'd1,   4'd10}, // R10 late
        '{1'b1, 3'd4, 14'd100,  7'h20, 4'd0, 6'd36, 16'd1,   4'd10}, // R10 defer
        '{1'b1, 3'd5, 14'd100,  7'h00, 4'd0, 6'd31, 16'd100, 4'd11}  // R11
    };

    function automatic logic [17:0] waddr(input int p, input int w);
        return 18'h20000 | 18'(p << 8) | 18'(w << 2);
    endfunction

    task automatic check(input bit ok, input int req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [17:0] a, output logic [CW-1:0] d, output logic v);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en   = 1'b0;
        d = rd_data;
        v = rd_valid;
    endtask

    task automatic send(input logic tx, input int p, input int len, input int flags, input int coll);
        @(negedge clk);
        if (tx) begin
            tx_done[p] = 1'b1; tx_len[p] = LW'(len); tx_flags[p] = 6'(flags); tx_coll[p] = 4'(coll);
        end else begin
            rx_done[p] = 1'b1; rx_len[p] = LW'(len); rx_flags[p] = 7'(flags);
        end
        @(negedge clk);
        rx_done = '0; tx_done = '0;
    endtask

    task automatic drain(input int p);
        logic [CW-1:0] d;
        logic v;
        for (int w = 0; w < 64; w++) do_read(waddr(p, w), d, v);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CW-1:0] d;
        logic v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(rd_valid == 1'b0, 1, int'(rd_valid), 0);
        check(rd_data == '0, 1, int'(rd_data), 0);
        do_read(waddr(0, 0), d, v);
        check(d == '0, 1, int'(d), 0);
        do_read(waddr(5, 36), d, v);
        check(d == '0, 1, int'(d), 0);
        // R2: valid follows the request
        check(v == 1'b1, 2, int'(v), 1);
        @(negedge clk);
        check(rd_valid == 1'b0 && rd_data == '0, 2, int'(rd_valid), 0);

        // Table of frames, each checked against a fresh bank
        for (int i = 0; i < NV; i++) begin
            drain(int'(VEC[i].port));
            send(VEC[i].tx, int'(VEC[i].port), int'(VEC[i].len), int'(VEC[i].flags), int'(VEC[i].coll));
            do_read(waddr(int'(VEC[i].port), int'(VEC[i].word)), d, v);
            check(d == VEC[i].exp, int'(VEC[i].req), int'(d), int'(VEC[i].exp));
        end

        // R3: clear on read
        drain(4);
        send(1'b0, 4, 64, 1, 0);
        send(1'b0, 4, 64, 1, 0);
        do_read(waddr(4, 0), d, v);
        check(d == 16'd2, 3, int'(d), 2);
        do_read(waddr(4, 0), d, v);
        check(d == 16'd0, 3, int'(d), 0);

        // R4: increment in the read cycle
        drain(0);
        for (int k = 0; k < 3; k++) send(1'b0, 0, 64, 1, 0);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = waddr(0, 0);
        rx_done[0] = 1'b1; rx_len[0] = LW'(64); rx_flags[0] = 7'h01;
        @(negedge clk);
        rd_en = 1'b0; rx_done = '0;
        check(rd_data == 16'd3, 4, int'(rd_data), 3);
        do_read(waddr(0, 0), d, v);
        check(d == 16'd1, 4, int'(d), 1);

        // R5: misses return zero and clear nothing
        drain(0);
        send(1'b0, 0, 64, 1, 0);
        do_read(18'h10000, d, v);
        check(d == '0, 5, int'(d), 0);
        do_read(waddr(0, 0) | 18'd1, d, v);
        check(d == '0, 5, int'(d), 0);
        do_read(waddr(7, 0), d, v);
        check(d == '0, 5, int'(d), 0);
        do_read(waddr(0, 40), d, v);
        check(d == '0, 5, int'(d), 0);
        do_read(waddr(0, 0), d, v);
        check(d == 16'd1, 5, int'(d), 1);

        // R12: byte total wraps modulo 2^16
        drain(1);
        for (int k = 0; k < 44; k++) send(1'b0, 1, 1500, 0, 0);
        do_read(waddr(1, 17), d, v);
        check(d == 16'd464, 12, int'(d), 464);

        // R13: ports are independent
        drain(2);
        drain(3);
        send(1'b0, 2, 64, 1, 0);
        do_read(waddr(3, 0), d, v);
        check(d == '0, 13, int'(d), 0);
        do_read(waddr(2, 0), d, v);
        check(d == 16'd1, 13, int'(d), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule